// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer with Locked Modulator Strobe

This block is the switching timer for a three-phase motor power stage. One up/down counter rises from zero to a programmable half-period value `H` and falls back to zero, so a full switching period lasts `2*H` clocks. Each of the three phases compares its duty value against that counter. The result drives a high-side gate and a complementary low-side gate. A fixed dead band is inserted between them on every transition. Because the counter is symmetric, every on-time is centered on the counter's zero point. The ripple in the phase current therefore has zero mean at that instant.

At each zero point the timer issues a one-clock sync pulse, which tells the current-sampling logic where to sample. It also produces a clock-enable strobe for an oversampling converter's modulator. That strobe is derived from the same counter, so every switching period contains exactly `DECIM` equally spaced strobes. Harmonics of the switching ripple then fold onto DC after decimation. The half-period and the three duty values are written through shadow registers. They take effect only at the boundary of a period, so a write never produces a partial or glitched period.

A half-period that cannot be split into `DECIM` equal strobe intervals is rejected. The error flag rises and the timer idles until a valid value arrives.

Top module: `cpwm_sync_timer`

## Requirements
- R1: With a valid half-period `H`, the counter runs 0 up to `H` and back, so consecutive sync pulses are exactly `2*H` clocks apart.
- R2: `sync_o` is high for exactly one clock per period, in the cycle where the counter is zero.
- R3: `mod_stb_o` fires exactly `DECIM` times per period, every `2*H/DECIM` clocks. One of these strobes falls in the same cycle as `sync_o`.
- R4: Values on `half_per_i` and `duty_i` are captured only in the clock before the counter returns to zero. A change made in the middle of a period affects neither that period's length nor its gate outputs. The new values apply from the next sync onward.
- R5: For a phase with duty `d` in the range 1 to `H`, the compare result is high for `2*d-1` clocks per period, centered on the sync cycle. The high-side gate is on for that width minus `DEAD_CYC`, or zero if the width is shorter.
- R6: After any change of a phase's compare result, both of its gates are off for `DEAD_CYC` clocks before the newly selected side turns on. The low-side on-time per period is therefore `2*H - w - DEAD_CYC`, where `w` is the compare width and 0 < w < 2*H.
- R7: The high-side and low-side gates of one phase are never on together.
- R8: A duty of 0 keeps the high side off and the low side on for the whole period. A duty above `H` keeps the high side on and the low side off for the whole period.
- R9: A non-zero `H` that is not a multiple of `DECIM/2` sets `cfg_err_o` and idles the timer: no sync, no strobes, all high sides off and all low sides on. `H = 0` idles the timer the same way with `cfg_err_o` low.
- R10: During and just after reset, all high sides are off, all low sides are on, and `sync_o`, `mod_stb_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_per_i | input | CNT_W | Requested half-period in clocks (shadowed) |
| duty_i | input | NPH*CNT_W | Per-phase duty compare values, phase 0 in the low bits (shadowed) |
| gate_hi_o | output | NPH | High-side gate drive per phase |
| gate_lo_o | output | NPH | Low-side gate drive per phase |
| sync_o | output | 1 | One-clock pulse at the center of each period |
| mod_stb_o | output | 1 | Modulator clock-enable strobe, DECIM per period |
| cfg_err_o | output | 1 | Captured half-period is not a multiple of DECIM/2 |

## Verification
The checker assumes that `DECIM` is a power of two and at least 2, and that any valid half-period fits the counter width. Under these assumptions the strobe spacing is an integer, and a period is always at least two clocks long, so a sync pulse is never followed by another one. The stimulus uses only aligned half-periods between 32 and 128 with the default `DECIM` of 64. It picks duties from 0 to one above the half-period, which covers both saturation ends. Misaligned and zero half-periods are applied only in a dedicated idle phase. Mid-period writes are made at cycles counted from an observed sync pulse.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/cpwm_updown_cnt.sv
module cpwm_updown_cnt
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  cnt_dir_e         dir_q, dir_nx;

  always_comb begin
    if (!run_i) begin
      cnt_nx = '0;
    end else if (dir_q == DIR_UP) begin
      cnt_nx = (cnt_q == top_i) ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end else begin
      cnt_nx = cnt_q - 1'b1;
    end
    // turn upward once zero is reached; also covers a top of 1
    if ((cnt_nx == '0) || (dir_q == DIR_UP && cnt_q != top_i)) dir_nx = DIR_UP;
    else dir_nx = DIR_DN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_nx;
      dir_q <= dir_nx;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_nx == '0);
endmodule

// File: rtl/cpwm_stb_div.sv
module cpwm_stb_div #(
  parameter int CNT_W = 16,
  parameter int DECIM = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] hp_i,
  output logic             stb_o
);
  localparam int STEP_SH = $clog2(DECIM) - 1;

  logic [CNT_W-1:0] step, rem_q;

  // 2*H/DECIM == H >> (log2(DECIM)-1)
  assign step  = hp_i >> STEP_SH;
  assign stb_o = run_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else if (!run_i) rem_q <= '0;
    else if (rem_q == '0) rem_q <= step - 1'b1;
    else rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/cpwm_dead_band.sv
module cpwm_dead_band #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int DT_W = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

  logic            lvl_q;
  logic [DT_W-1:0] dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      dt_q  <= '0;
    end else if (ref_i != lvl_q) begin
      lvl_q <= ref_i;
      dt_q  <= DT_W'(DEAD_CYC);
    end else if (dt_q != '0) begin
      dt_q <= dt_q - 1'b1;
    end
  end

  assign hi_o = lvl_q && (dt_q == '0);
  assign lo_o = !lvl_q && (dt_q == '0);
endmodule

// File: rtl/cpwm_sync_timer.sv
module cpwm_sync_timer #(
  parameter int CNT_W    = 16,
  parameter int NPH      = 3,
  parameter int DECIM    = 64,
  parameter int DEAD_CYC = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     half_per_i,
  input  logic [NPH*CNT_W-1:0] duty_i,
  output logic [NPH-1:0]       gate_hi_o,
  output logic [NPH-1:0]       gate_lo_o,
  output logic                 sync_o,
  output logic                 mod_stb_o,
  output logic                 cfg_err_o
);
  localparam int              HALF_D     = DECIM / 2;
  localparam logic [CNT_W-1:0] ALIGN_MASK = CNT_W'(HALF_D - 1);

  logic [CNT_W-1:0]     hp_sh;
  logic [NPH*CNT_W-1:0] duty_sh;
  logic [CNT_W-1:0]     cnt;
  logic                 load, run, aligned;
  logic [NPH-1:0]       cmp;

  assign aligned   = ((hp_sh & ALIGN_MASK) == '0);
  assign run       = (hp_sh != '0) && aligned;
  assign cfg_err_o = (hp_sh != '0) && !aligned;

  // shadow capture in the clock that precedes count zero (every clock while idle)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_sh   <= '0;
      duty_sh <= '0;
    end else if (load) begin
      hp_sh   <= half_per_i;
      duty_sh <= duty_i;
    end
  end

  cpwm_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .top_i  (hp_sh),
    .cnt_o  (cnt),
    .wrap_o (load)
  );

  assign sync_o = run && (cnt == '0);

  cpwm_stb_div #(.CNT_W(CNT_W), .DECIM(DECIM)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .hp_i   (hp_sh),
    .stb_o  (mod_stb_o)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign cmp[p] = run && (duty_sh[p*CNT_W +: CNT_W] > cnt);

    cpwm_dead_band #(.DEAD_CYC(DEAD_CYC)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (cmp[p]),
      .hi_o   (gate_hi_o[p]),
      .lo_o   (gate_lo_o[p])
    );
  end
endmodule

// File: rtl/cpwm_sync_timer_chk.sv
module cpwm_sync_timer_chk #(
  parameter int CNT_W    = 16,
  parameter int NPH      = 3,
  parameter int DECIM    = 64,
  parameter int DEAD_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPH-1:0]   gate_hi_o,
  input logic [NPH-1:0]   gate_lo_o,
  input logic             sync_o,
  input logic             mod_stb_o,
  input logic             cfg_err_o,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] hp_i
);
  localparam int SC_W = $clog2(DECIM + 1) + 1;

  logic [SC_W-1:0] stb_cnt;
  logic            seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_cnt <= '0;
      seen    <= 1'b0;
    end else if (!run_i) begin
      stb_cnt <= '0;
      seen    <= 1'b0;
    end else if (sync_o) begin
      stb_cnt <= SC_W'(1);
      seen    <= 1'b1;
    end else if (mod_stb_o) begin
      stb_cnt <= stb_cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_i <= hp_i); // R1
  AST_SYNC_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o); // R2
  AST_SYNC_HAS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> mod_stb_o); // R3
  AST_STB_PER_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && sync_o) |-> stb_cnt == SC_W'(DECIM)); // R3
  AST_SHADOW_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hp_i) |-> cnt_i == '0); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == '0); // R7
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!sync_o && !mod_stb_o)); // R9
  AST_HI_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && $past(!run_i)) |-> gate_hi_o == '0); // R9

  if (DEAD_CYC > 0) begin : g_dead
    for (genvar p = 0; p < NPH; p++) begin : g_ph
      AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gate_hi_o[p]) |-> !gate_lo_o[p]); // R6
    end
  end
endmodule

bind cpwm_sync_timer cpwm_sync_timer_chk #(
  .CNT_W(CNT_W), .NPH(NPH), .DECIM(DECIM), .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_hi_o (gate_hi_o),
  .gate_lo_o (gate_lo_o),
  .sync_o    (sync_o),
  .mod_stb_o (mod_stb_o),
  .cfg_err_o (cfg_err_o),
  .run_i     (run),
  .cnt_i     (cnt),
  .hp_i      (hp_sh)
);

// File: tb/cpwm_sync_timer_tb.sv
`timescale 1ns/1ps
module cpwm_sync_timer_tb;
  localparam int CNT_W = 16;
  localparam int NPH   = 3;
  localparam int DECIM = 64;
  localparam int DEAD  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0]     half_per = '0;
  logic [NPH*CNT_W-1:0] duty = '0;
  logic [NPH-1:0]       gate_hi, gate_lo;
  logic                 sync, stb, cfg_err;

  always #5 clk = ~clk;

  cpwm_sync_timer #(.CNT_W(CNT_W), .NPH(NPH), .DECIM(DECIM), .DEAD_CYC(DEAD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .half_per_i(half_per), .duty_i(duty),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .sync_o(sync), .mod_stb_o(stb),
    .cfg_err_o(cfg_err)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // negedge monitor: per-period statistics
  int cyc = 0, nper = 0, prev_sync = 0, last_stb = 0;
  bit have_sync = 0;
  int cur_stb, cur_min, cur_max, last_len, last_stbn, last_min, last_max;
  int cur_hi[NPH], cur_lo[NPH], last_hi[NPH], last_lo[NPH];
  int sync_total = 0, stb_total = 0, overlap = 0, dbl_sync = 0;
  logic sync_d = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (stb) begin
        if (cyc - last_stb < cur_min) cur_min = cyc - last_stb;
        if (cyc - last_stb > cur_max) cur_max = cyc - last_stb;
        last_stb = cyc;
        stb_total++;
      end
      if (sync) begin
        sync_total++;
        if (sync_d) dbl_sync++;
        if (have_sync) begin
          last_len = cyc - prev_sync; last_stbn = cur_stb;
          last_min = cur_min; last_max = cur_max;
          for (int p = 0; p < NPH; p++) begin last_hi[p] = cur_hi[p]; last_lo[p] = cur_lo[p]; end
          nper++;
        end
        have_sync = 1; prev_sync = cyc;
        cur_stb = 0; cur_min = 1 << 30; cur_max = 0;
        for (int p = 0; p < NPH; p++) begin cur_hi[p] = 0; cur_lo[p] = 0; end
      end
      cur_stb += int'(stb);
      for (int p = 0; p < NPH; p++) begin
        cur_hi[p] += int'(gate_hi[p]);
        cur_lo[p] += int'(gate_lo[p]);
      end
      if ((gate_hi & gate_lo) != '0) overlap++;
      sync_d = sync;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wid(int d, int h);
    if (d == 0) return 0;
    if (d > h) return 2 * h;
    return 2 * d - 1;
  endfunction

  function automatic int exp_hi(int d, int h);
    int w = wid(d, h);
    if (w == 2 * h) return 2 * h;
    if (w <= DEAD) return 0;
    return w - DEAD;
  endfunction

  function automatic int exp_lo(int d, int h);
    int w = wid(d, h);
    int r;
    if (w == 0) return 2 * h;
    if (w == 2 * h) return 0;
    r = 2 * h - w - DEAD;
    return (r < 0) ? 0 : r;
  endfunction

  task automatic set_cfg(input int h, input int d0, input int d1, input int d2);
    half_per = CNT_W'(h);
    duty = {CNT_W'(d2), CNT_W'(d1), CNT_W'(d0)};
  endtask

  task automatic wait_per(input int n);
    int tgt = nper + n;
    while (nper < tgt) @(negedge clk);
  endtask

  task automatic steady(input int h, input int d0, input int d1, input int d2);
    int d[NPH];
    d[0] = d0; d[1] = d1; d[2] = d2;
    set_cfg(h, d0, d1, d2);
    wait_per(3);
    chk(last_len == 2 * h, "R1 period length", last_len, 2 * h);
    chk(last_stbn == DECIM, "R3 strobes per period", last_stbn, DECIM);
    chk(last_min == 2 * h / DECIM && last_max == 2 * h / DECIM, "R3 strobe spacing",
        last_max, 2 * h / DECIM);
    for (int p = 0; p < NPH; p++) begin
      chk(last_hi[p] == exp_hi(d[p], h), "R5 R8 high-side on-time", last_hi[p], exp_hi(d[p], h));
      chk(last_lo[p] == exp_lo(d[p], h), "R6 R8 low-side on-time", last_lo[p], exp_lo(d[p], h));
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed, s_sync, s_stb, hh, n;
    seed = 32'h1bad5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(gate_lo == '1 && gate_hi == '0, "R10 gates in reset", int'({gate_hi, gate_lo}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate_hi == '0 && gate_lo == '1, "R10 gates after reset", int'({gate_hi, gate_lo}), 7);
    chk(!sync && !stb && !cfg_err, "R10 flags after reset", int'({sync, stb, cfg_err}), 0);

    // directed corners: zero duty, full duty, duty = H, tiny pulse
    steady(32, 0, 33, 32);
    steady(64, 1, 2, 3);
    steady(128, 64, 100, 129);

    // R4: mid-period half-period change
    set_cfg(64, 10, 20, 30);
    wait_per(3);
    while (!sync) @(negedge clk);
    repeat (10) @(negedge clk);
    set_cfg(96, 10, 20, 30);
    wait_per(1);
    chk(last_len == 128, "R4 current period keeps old length", last_len, 128);
    wait_per(1);
    chk(last_len == 192, "R4 next period uses new length", last_len, 192);

    // R4: mid-period duty change has no effect until next sync
    set_cfg(64, 0, 0, 0);
    wait_per(3);
    while (!sync) @(negedge clk);
    repeat (5) @(negedge clk);
    set_cfg(64, 65, 0, 0);
    repeat (2 * 64 - 1 - 5) @(negedge clk);
    chk(gate_hi[0] == 1'b0 && !sync, "R4 duty held until boundary", int'(gate_hi[0]), 0);
    @(negedge clk);
    chk(sync == 1'b1, "R2 sync at boundary", int'(sync), 1);
    repeat (DEAD + 1) @(negedge clk);
    chk(gate_hi[0] == 1'b1, "R4 R6 new duty after dead time", int'(gate_hi[0]), 1);

    // random configurations
    for (int i = 0; i < 6; i++) begin
      hh = 32 * (1 + $urandom_range(3, 0));
      steady(hh, $urandom_range(hh + 1, 0), $urandom_range(hh + 1, 0), $urandom_range(hh + 1, 0));
    end

    // R9: misaligned half-period
    set_cfg(40, 10, 20, 30);
    n = 0;
    while (!cfg_err && n < 1000) begin @(negedge clk); n++; end
    chk(cfg_err == 1'b1, "R9 error flag on misaligned period", int'(cfg_err), 1);
    s_sync = sync_total; s_stb = stb_total;
    repeat (300) @(negedge clk);
    chk(sync_total == s_sync && stb_total == s_stb, "R9 no sync or strobe when misaligned",
        sync_total - s_sync + stb_total - s_stb, 0);
    chk(gate_hi == '0 && gate_lo == '1, "R9 gates idle on error", int'({gate_hi, gate_lo}), 7);

    // R9: zero half-period idles without error
    set_cfg(0, 10, 20, 30);
    repeat (5) @(negedge clk);
    chk(cfg_err == 1'b0, "R9 zero period clears error", int'(cfg_err), 0);
    s_sync = sync_total;
    repeat (200) @(negedge clk);
    chk(sync_total == s_sync, "R9 no sync with zero period", sync_total - s_sync, 0);
    chk(gate_hi == '0 && gate_lo == '1, "R9 gates idle at zero period", int'({gate_hi, gate_lo}), 7);

    steady(32, 16, 5, 0);

    chk(overlap == 0, "R7 no high/low overlap", overlap, 0);
    chk(dbl_sync == 0, "R2 sync one clock wide", dbl_sync, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule